// File: doc/BRIEF.md
# Context Register Remapping Stage

This block is one pipeline stage between decode and register read in an in-order core that runs loops split into an Access part (loads into registers) and an Execute part (uses those registers). Software tags each instruction with a phase and a context id. When an Access-phase instruction writes an architectural register, the stage points that register at a spare physical register owned by the context. A later Execute-phase instruction of the same context then reads the value through the same mapping. Several loop iterations can therefore run their Access parts ahead of their Execute parts without using up architectural names.

A pool of spare physical registers sits above the identity-mapped range. Each context keeps a per-register valid flag and a slot number. A context opens implicitly with its first Access write. Software closes it with a release pulse, which in a single cycle returns every slot the context owns and clears its flags. The stage adds exactly one cycle of latency. It asserts a combinational stall when it cannot accept the presented instruction. The upstream stage must then hold that instruction.

Top module: `ctx_remap_stage`

## Requirements
- R1: After reset the output valid and stall are low, every spare register is free, and no context holds a mapping. The first allocation therefore yields physical register ARCH_REGS (16 by default).
- R2: Phase code 2'b00 (normal) and the reserved code 2'b11 map the two sources and the destination to themselves (physical = architectural).
- R3: An accepted Access-phase instruction (phase 2'b01) with write-enable high, whose destination has no mapping in its context, takes the lowest-numbered free spare slot k. Its destination output is ARCH_REGS+k.
- R4: A second Access write to an already-mapped register of the same context reuses that mapping and consumes no new slot, even when the pool is empty.
- R5: In the Execute phase (2'b10), sources translate through the context's table and the destination keeps the identity mapping.
- R6: In the Access phase, sources also translate through the context's table, so later Access instructions see earlier in-phase writes.
- R7: A source lookup whose context entry is not valid returns the identity mapping.
- R8: A release of context c returns all of c's slots to the pool and clears all of c's valid flags in one cycle. From the next cycle on, c's lookups return identity and its slots can be allocated again.
- R9: When an allocation is needed and the pool is empty, stall is high, the instruction is not accepted, and the pool is left unchanged.
- R10: In any cycle with a release pulse, stall is high and no instruction is accepted.
- R11: An instruction presented with valid high and stall low appears on the outputs, with out_valid high, after exactly one clock edge. Otherwise out_valid is low after that edge.
- R12: An Access instruction with write-enable low allocates nothing, and its destination keeps the identity mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_phase | input | 2 | 00 normal, 01 Access, 10 Execute, 11 treated as normal |
| in_ctx | input | $clog2(CONTEXTS) | Context id |
| in_src_a | input | $clog2(ARCH_REGS) | First source specifier |
| in_src_b | input | $clog2(ARCH_REGS) | Second source specifier |
| in_dst | input | $clog2(ARCH_REGS) | Destination specifier |
| in_we | input | 1 | Instruction writes its destination |
| rel_valid | input | 1 | Release-context pulse |
| rel_ctx | input | $clog2(CONTEXTS) | Context to release |
| stall | output | 1 | Instruction not accepted this cycle |
| out_valid | output | 1 | Renamed instruction valid |
| out_src_a | output | $clog2(ARCH_REGS+EXTRA_REGS) | Physical first source |
| out_src_b | output | $clog2(ARCH_REGS+EXTRA_REGS) | Physical second source |
| out_dst | output | $clog2(ARCH_REGS+EXTRA_REGS) | Physical destination |
| out_we | output | 1 | Registered write-enable |

## Verification
The bench builds the stage with the default values: 16 architectural registers, 4 contexts, 16 spare registers and lowest-first allocation. With these values one context alone can drain the whole pool with its own 16 registers. This makes the empty-pool stall and reuse-under-empty cases reachable in a short directed run. Random traffic over four contexts with occasional releases then exhausts and refills the pool many times. This exercises cross-context isolation and single-cycle return of scattered slots.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
   typedef enum logic [1:0] {
      PH_NORMAL = 2'b00,
      PH_ACCESS = 2'b01,
      PH_EXEC   = 2'b10,
      PH_RSVD   = 2'b11
   } phase_e;
endpackage

// File: rtl/rmp_free_pool.sv
module rmp_free_pool #(
   parameter int EXTRA     = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int EW       = $clog2(EXTRA)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [EXTRA-1:0] ret_mask,
   output logic [EW-1:0]    pick,
   output logic             empty,
   output logic [EXTRA-1:0] free_mask
);
   logic [EXTRA-1:0] free_q;
   logic [EXTRA-1:0] take_hot;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            pick = '0;
            for (int i = EXTRA - 1; i >= 0; i--) begin
               if (free_q[i]) pick = EW'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            pick = '0;
            for (int i = 0; i < EXTRA; i++) begin
               if (free_q[i]) pick = EW'(i);
            end
         end
      end
   endgenerate

   assign empty     = ~|free_q;
   assign take_hot  = take ? (EXTRA'(1) << pick) : '0;
   assign free_mask = free_q;

   always_ff @(posedge clk) begin
      if (!rst_n) free_q <= '1;
      else        free_q <= (free_q & ~take_hot) | ret_mask;
   end
endmodule

// File: rtl/rmp_ctx_table.sv
module rmp_ctx_table #(
   parameter int ARCH  = 16,
   parameter int CTXS  = 4,
   parameter int EXTRA = 16,
   localparam int AW   = $clog2(ARCH),
   localparam int CW   = $clog2(CTXS),
   localparam int EW   = $clog2(EXTRA)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    rd_ctx,
   input  logic [AW-1:0]    rd_a,
   input  logic [AW-1:0]    rd_b,
   input  logic [AW-1:0]    rd_d,
   output logic             a_hit,
   output logic [EW-1:0]    a_slot,
   output logic             b_hit,
   output logic [EW-1:0]    b_slot,
   output logic             d_hit,
   output logic [EW-1:0]    d_slot,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_arch,
   input  logic [EW-1:0]    wr_slot,
   input  logic             rel_en,
   input  logic [CW-1:0]    rel_ctx,
   output logic [EXTRA-1:0] rel_owned
);
   logic [ARCH-1:0]  vld_w  [CTXS];
   logic [EW-1:0]    slot_w [CTXS][ARCH];
   logic [EXTRA-1:0] own_w  [CTXS];

   generate
      for (genvar g = 0; g < CTXS; g++) begin : g_ctx
         logic [ARCH-1:0]  vld_q;
         logic [EW-1:0]    slot_q [ARCH];
         logic [EXTRA-1:0] own_q;
         logic             hit_rel;
         logic             hit_wr;

         assign hit_rel = rel_en && (rel_ctx == CW'(g));
         assign hit_wr  = wr_en && (rd_ctx == CW'(g)) && !hit_rel;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= '0;
               own_q <= '0;
            end else if (hit_rel) begin
               vld_q <= '0;
               own_q <= '0;
            end else if (hit_wr) begin
               vld_q[wr_arch] <= 1'b1;
               own_q[wr_slot] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (hit_wr) slot_q[wr_arch] <= wr_slot;
         end

         assign vld_w[g]  = vld_q;
         assign slot_w[g] = slot_q;
         assign own_w[g]  = own_q;
      end
   endgenerate

   assign a_hit     = vld_w[rd_ctx][rd_a];
   assign a_slot    = slot_w[rd_ctx][rd_a];
   assign b_hit     = vld_w[rd_ctx][rd_b];
   assign b_slot    = slot_w[rd_ctx][rd_b];
   assign d_hit     = vld_w[rd_ctx][rd_d];
   assign d_slot    = slot_w[rd_ctx][rd_d];
   assign rel_owned = own_w[rel_ctx];
endmodule

// File: rtl/ctx_remap_stage.sv
module ctx_remap_stage #(
   parameter int ARCH_REGS       = 16,
   parameter int CONTEXTS        = 4,
   parameter int EXTRA_REGS      = 16,
   parameter bit ALLOC_LOW_FIRST = 1'b1,
   localparam int AW = $clog2(ARCH_REGS),
   localparam int CW = $clog2(CONTEXTS),
   localparam int EW = $clog2(EXTRA_REGS),
   localparam int PW = $clog2(ARCH_REGS + EXTRA_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    in_phase,
   input  logic [CW-1:0] in_ctx,
   input  logic [AW-1:0] in_src_a,
   input  logic [AW-1:0] in_src_b,
   input  logic [AW-1:0] in_dst,
   input  logic          in_we,
   input  logic          rel_valid,
   input  logic [CW-1:0] rel_ctx,
   output logic          stall,
   output logic          out_valid,
   output logic [PW-1:0] out_src_a,
   output logic [PW-1:0] out_src_b,
   output logic [PW-1:0] out_dst,
   output logic          out_we
);
   import rmp_pkg::*;

   generate
      if (ARCH_REGS < 2 || (1 << AW) != ARCH_REGS) begin : g_bad_arch
         $error("ARCH_REGS must be a power of two of at least 2");
      end
      if (CONTEXTS < 2 || (1 << CW) != CONTEXTS) begin : g_bad_ctx
         $error("CONTEXTS must be a power of two of at least 2");
      end
      if (EXTRA_REGS < 2 || (1 << EW) != EXTRA_REGS) begin : g_bad_extra
         $error("EXTRA_REGS must be a power of two of at least 2");
      end
   endgenerate

   phase_e             phase;
   logic               is_acc;
   logic               use_tbl;
   logic               a_hit, b_hit, d_hit;
   logic [EW-1:0]      a_slot, b_slot, d_slot;
   logic [EW-1:0]      pick;
   logic               pool_empty;
   logic [EXTRA_REGS-1:0] free_mask;
   logic [EXTRA_REGS-1:0] rel_owned;
   logic [EXTRA_REGS-1:0] ret_mask;
   logic               need_alloc;
   logic               accept;
   logic               take;
   logic [PW-1:0]      phys_a, phys_b, phys_d;

   function automatic logic [PW-1:0] to_spare(input logic [EW-1:0] slot);
      return PW'(ARCH_REGS) + PW'(slot);
   endfunction

   assign phase   = phase_e'(in_phase);
   assign is_acc  = (phase == PH_ACCESS);
   assign use_tbl = (phase == PH_ACCESS) || (phase == PH_EXEC);

   rmp_ctx_table #(
      .ARCH (ARCH_REGS),
      .CTXS (CONTEXTS),
      .EXTRA(EXTRA_REGS)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_ctx   (in_ctx),
      .rd_a     (in_src_a),
      .rd_b     (in_src_b),
      .rd_d     (in_dst),
      .a_hit    (a_hit),
      .a_slot   (a_slot),
      .b_hit    (b_hit),
      .b_slot   (b_slot),
      .d_hit    (d_hit),
      .d_slot   (d_slot),
      .wr_en    (take),
      .wr_arch  (in_dst),
      .wr_slot  (pick),
      .rel_en   (rel_valid),
      .rel_ctx  (rel_ctx),
      .rel_owned(rel_owned)
   );

   assign ret_mask = rel_valid ? rel_owned : '0;

   rmp_free_pool #(
      .EXTRA    (EXTRA_REGS),
      .LOW_FIRST(ALLOC_LOW_FIRST)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .ret_mask (ret_mask),
      .pick     (pick),
      .empty    (pool_empty),
      .free_mask(free_mask)
   );

   assign need_alloc = in_valid && in_we && is_acc && !d_hit;
   assign stall      = rel_valid || (need_alloc && pool_empty);
   assign accept     = in_valid && !stall;
   assign take       = accept && need_alloc;

   always_comb begin
      phys_a = (use_tbl && a_hit) ? to_spare(a_slot) : PW'(in_src_a);
      phys_b = (use_tbl && b_hit) ? to_spare(b_slot) : PW'(in_src_b);
      if (is_acc && in_we) begin
         phys_d = d_hit ? to_spare(d_slot) : to_spare(pick);
      end else begin
         phys_d = PW'(in_dst);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_src_a <= '0;
         out_src_b <= '0;
         out_dst   <= '0;
         out_we    <= 1'b0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_src_a <= phys_a;
            out_src_b <= phys_b;
            out_dst   <= phys_d;
            out_we    <= in_we;
         end
      end
   end
endmodule

// File: rtl/ctx_remap_chk.sv
module ctx_remap_chk #(
   parameter int ARCH  = 16,
   parameter int EXTRA = 16,
   parameter int AW    = 4,
   parameter int CW    = 2,
   parameter int PW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_phase,
   input logic [AW-1:0]    in_src_a,
   input logic [AW-1:0]    in_dst,
   input logic             in_we,
   input logic             rel_valid,
   input logic             stall,
   input logic             out_valid,
   input logic [PW-1:0]    out_src_a,
   input logic [PW-1:0]    out_dst,
   input logic [EXTRA-1:0] free_mask
);
   // R11
   accept_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stall) |=> out_valid);

   // R11
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && !stall) |=> !out_valid);

   // R10
   release_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> stall);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !rel_valid) |=> $stable(free_mask));

   // R2
   normal_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stall && (in_phase == 2'b00)) |=>
         (out_dst == PW'($past(in_dst)) && out_src_a == PW'($past(in_src_a))));

   // R5
   exec_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stall && (in_phase == 2'b10)) |=> (out_dst < PW'(ARCH)));

   // R12
   no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rel_valid && !(in_valid && in_we && (in_phase == 2'b01))) |=> $stable(free_mask));
endmodule

bind ctx_remap_stage ctx_remap_chk #(
   .ARCH (ARCH_REGS),
   .EXTRA(EXTRA_REGS),
   .AW   (AW),
   .CW   (CW),
   .PW   (PW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_phase (in_phase),
   .in_src_a (in_src_a),
   .in_dst   (in_dst),
   .in_we    (in_we),
   .rel_valid(rel_valid),
   .stall    (stall),
   .out_valid(out_valid),
   .out_src_a(out_src_a),
   .out_dst  (out_dst),
   .free_mask(free_mask)
);

// File: tb/ctx_remap_stage_bench.sv
module ctx_remap_stage_bench;
   localparam int NA = 16;
   localparam int NC = 4;
   localparam int NE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_phase = '0;
   logic [1:0] in_ctx = '0;
   logic [3:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic       in_we = 1'b0;
   logic       rel_valid = 1'b0;
   logic [1:0] rel_ctx = '0;
   logic       stall, out_valid, out_we;
   logic [4:0] out_src_a, out_src_b, out_dst;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   bit m_vld  [NC][NA];
   int m_slot [NC][NA];
   bit m_own  [NC][NE];
   bit m_free [NE];

   always #5 clk = ~clk;

   ctx_remap_stage u_ctx_remap_stage (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
      .in_ctx(in_ctx), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .in_we(in_we), .rel_valid(rel_valid), .rel_ctx(rel_ctx), .stall(stall),
      .out_valid(out_valid), .out_src_a(out_src_a), .out_src_b(out_src_b),
      .out_dst(out_dst), .out_we(out_we)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int low_free();
      for (int i = 0; i < NE; i++) if (m_free[i]) return i;
      return -1;
   endfunction

   function automatic int map_src(input int c, input int ph, input int r);
      if ((ph == 1 || ph == 2) && m_vld[c][r]) return NA + m_slot[c][r];
      return r;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < NC; c++) begin
         for (int r = 0; r < NA; r++) begin m_vld[c][r] = 1'b0; m_slot[c][r] = 0; end
         for (int e = 0; e < NE; e++) m_own[c][e] = 1'b0;
      end
      for (int e = 0; e < NE; e++) m_free[e] = 1'b1;
   endtask

   // One instruction slot: drive at negedge, check stall, check outputs after the edge.
   task automatic cyc(input string tag, input bit v, input int ph, input int c,
                      input int a, input int b, input int d, input bit we,
                      input bit rv, input int rc);
      bit need, exp_stall, acc;
      int ea, eb, ed, lf;
      @(negedge clk);
      in_valid = v; in_phase = 2'(ph); in_ctx = 2'(c);
      in_src_a = 4'(a); in_src_b = 4'(b); in_dst = 4'(d); in_we = we;
      rel_valid = rv; rel_ctx = 2'(rc);
      #1;
      lf = low_free();
      need = v && we && (ph == 1) && !m_vld[c][d];
      exp_stall = rv || (need && lf < 0);
      acc = v && !exp_stall;
      chk({tag, " stall"}, int'(stall), int'(exp_stall));
      ea = map_src(c, ph, a);
      eb = map_src(c, ph, b);
      if (ph == 1 && we) ed = m_vld[c][d] ? NA + m_slot[c][d] : NA + lf;
      else ed = d;
      @(posedge clk);
      #1;
      chk({tag, " out_valid"}, int'(out_valid), int'(acc));
      if (acc) begin
         chk({tag, " src_a"}, int'(out_src_a), ea);
         chk({tag, " src_b"}, int'(out_src_b), eb);
         chk({tag, " dst"}, int'(out_dst), ed);
         chk({tag, " we"}, int'(out_we), int'(we));
      end
      if (rv) begin
         for (int e = 0; e < NE; e++) if (m_own[rc][e]) begin m_free[e] = 1'b1; m_own[rc][e] = 1'b0; end
         for (int r = 0; r < NA; r++) m_vld[rc][r] = 1'b0;
      end else if (acc && need) begin
         m_free[lf] = 1'b0; m_own[c][lf] = 1'b1;
         m_vld[c][d] = 1'b1; m_slot[c][d] = lf;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 stall", int'(stall), 0);

      cyc("R2 normal", 1, 0, 0, 3, 5, 7, 1, 0, 0);
      cyc("R2 reserved", 1, 3, 1, 2, 6, 9, 1, 0, 0);
      // R1 first allocation lands on physical 16
      cyc("R3 first alloc", 1, 1, 1, 0, 0, 4, 1, 0, 0);
      chk("R1 first slot", int'(out_dst), NA);
      // R4 rewrite reuses
      cyc("R4 reuse", 1, 1, 1, 0, 0, 4, 1, 0, 0);
      chk("R4 same phys", int'(out_dst), NA);
      cyc("R3 second alloc", 1, 1, 1, 0, 0, 5, 1, 0, 0);
      chk("R3 next slot", int'(out_dst), NA + 1);
      cyc("R6 access src", 1, 1, 1, 4, 5, 8, 0, 0, 0);
      chk("R6 src mapped", int'(out_src_a), NA);
      cyc("R5 exec", 1, 2, 1, 4, 5, 4, 1, 0, 0);
      chk("R5 src_b mapped", int'(out_src_b), NA + 1);
      chk("R5 dst identity", int'(out_dst), 4);
      cyc("R7 other ctx", 1, 2, 2, 4, 5, 1, 1, 0, 0);
      chk("R7 fallback", int'(out_src_a), 4);
      cyc("R12 no write", 1, 1, 1, 0, 0, 9, 0, 0, 0);
      chk("R12 dst identity", int'(out_dst), 9);
      cyc("R12 next alloc", 1, 1, 1, 0, 0, 10, 1, 0, 0);
      chk("R12 slot unused", int'(out_dst), NA + 2);
      // R10 release blocks the presented instruction
      cyc("R10 release", 1, 0, 0, 1, 1, 1, 1, 1, 1);
      chk("R10 bubble", int'(out_valid), 0);
      cyc("R8 cleared", 1, 2, 1, 4, 10, 0, 0, 0, 0);
      chk("R8 identity", int'(out_src_a), 4);
      cyc("R8 returned", 1, 1, 0, 0, 0, 0, 1, 0, 0);
      chk("R8 slot reused", int'(out_dst), NA);

      // Drain pool with context 0, then force the empty stall.
      for (int r = 1; r < NA; r++) cyc("R3 fill", 1, 1, 0, 0, 0, r, 1, 0, 0);
      cyc("R9 empty", 1, 1, 2, 0, 0, 1, 1, 0, 0);
      chk("R9 held", int'(out_valid), 0);
      cyc("R4 reuse empty", 1, 1, 0, 0, 0, 3, 1, 0, 0);
      chk("R4 no stall", int'(out_valid), 1);
      cyc("R8 release all", 0, 0, 0, 0, 0, 0, 0, 1, 0);
      cyc("R9 retry", 1, 1, 2, 0, 0, 1, 1, 0, 0);
      chk("R9 after free", int'(out_dst), NA);

      for (int n = 0; n < 4000; n++) begin
         bit rv = ($urandom_range(0, 11) == 0);
         cyc("R11 random", $urandom_range(0, 7) != 0, $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15),
             $urandom_range(0, 15), $urandom_range(0, 3) != 0, rv, $urandom_range(0, 3));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule